// File: doc/BRIEF.md
# Dual Reloading Interval Timer Pair

This block holds two independent down-counters behind a byte-wide write port. Timer A is 10 bits wide and timer B is 8 bits wide. Each timer has its own reload value and its own free-running prescaler. A timer that holds a non-zero count steps down once per prescaled tick. When it leaves the value 1, it reloads from its reload register and keeps running. A counter at zero is stopped. The only ways to start it are a load command issued while it is idle, or a reset.

Software cannot read or write the counters. It controls them through one command byte. For each timer, that byte holds a load bit, an interrupt-enable bit and a flag-clear bit. A load bit of 0 stops the timer by forcing its count to zero. A load bit of 1 starts an idle timer and leaves a running one alone. An expiry with the interrupt enabled latches a sticky per-timer flag. The flags appear in a status byte and drive a shared interrupt line.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, `status_o` reads 0, `irq_o` is 0, both counters are zero (stopped) and all reload registers hold 0.
- R2: A write to address 0x24 sets reload A bits 9..2. A write to 0x25 sets reload A bits 1..0 from data bits 1..0, and data bits 7..2 of that write are ignored. A write to 0x26 sets reload B. Writes to any address other than 0x24..0x27 change nothing.
- R3: A write to address 0x27 is a command. Bit 0 is load A, bit 1 is load B, bit 2 is interrupt enable A, bit 3 is interrupt enable B, bit 4 is clear flag A and bit 5 is clear flag B. Bits 7..6 have no effect. Each timer responds only to its own bits.
- R4: A command with a timer's load bit at 0 forces that counter to zero. A zero counter never expires.
- R5: A command with a timer's load bit at 1 copies the reload register into the counter only if the counter is zero. Otherwise the counter keeps its value. In the cycle of a command write, the counters do not step.
- R6: Timer A steps once every A_DIV clocks (default 288) and timer B once every B_DIV clocks (default 2304). The prescalers run freely from reset and are not restarted by writes. After loading value L, the first expiry comes between (L-1)*DIV+1 and L*DIV clocks after the load write.
- R7: On expiry, the counter reloads from the reload register value at that moment. Successive expiries are therefore exactly L*DIV clocks apart, and a new reload value takes effect from the next expiry.
- R8: An expiry sets the timer's flag (status bit 0 for A, bit 1 for B) only if that timer's interrupt enable is 1.
- R9: A flag stays set until a command writes 1 to its clear bit. Clearing the interrupt enable does not clear the flag.
- R10: `irq_o` is 1 exactly when at least one status flag is set.
- R11: Status bit 7 follows `busy_in`, and status bits 6..2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data |
| busy_in | input | 1 | Busy indication reflected in status bit 7 |
| status_o | output | 8 | Busy bit, zero padding, flag B, flag A |
| irq_o | output | 1 | Interrupt, OR of the two flags |

## Verification
A wrong count, a missed reload or a prescaler that restarts cannot be seen directly. It shows up only as a flag edge at the wrong clock, so the bench times each flag rise against L*DIV. A corrupted period becomes visible within one period. A wrong first-period phase becomes visible within one prescale interval of the expected window. Flag, enable and clear errors show on `status_o` and `irq_o` in the cycle after the offending write or expiry.

// File: rtl/dit_pkg.sv
package dit_pkg;
  // register addresses whose decode the timers depend on
  localparam logic [7:0] ADDR_A_HI = 8'h24;
  localparam logic [7:0] ADDR_A_LO = 8'h25;
  localparam logic [7:0] ADDR_B    = 8'h26;
  localparam logic [7:0] ADDR_CMD  = 8'h27;

  // command byte bit positions
  localparam int CB_LOAD_A = 0;
  localparam int CB_LOAD_B = 1;
  localparam int CB_IEN_A  = 2;
  localparam int CB_IEN_B  = 3;
  localparam int CB_CLR_A  = 4;
  localparam int CB_CLR_B  = 5;

  typedef struct packed {
    logic load;
    logic ien;
    logic clr;
  } chan_cmd_t;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int DIV = 288
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
#(
  parameter int A_WIDTH = 10,
  parameter int B_WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [A_WIDTH-1:0] reload_a,
  output logic [B_WIDTH-1:0] reload_b,
  output logic               cmd_wr,
  output chan_cmd_t          cmd_a,
  output chan_cmd_t          cmd_b
);
  localparam int A_LO = A_WIDTH - 8;

  logic [7:0]      a_hi;
  logic [A_LO-1:0] a_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hi     <= '0;
      a_lo     <= '0;
      reload_b <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_A_HI: a_hi     <= wr_data;
        ADDR_A_LO: a_lo     <= wr_data[A_LO-1:0];
        ADDR_B:    reload_b <= wr_data[B_WIDTH-1:0];
        default: ;
      endcase
    end
  end

  assign reload_a = {a_hi, a_lo};
  assign cmd_wr   = wr_en && (wr_addr == ADDR_CMD);

  always_comb begin
    cmd_a = '{load: wr_data[CB_LOAD_A], ien: wr_data[CB_IEN_A], clr: wr_data[CB_CLR_A]};
    cmd_b = '{load: wr_data[CB_LOAD_B], ien: wr_data[CB_IEN_B], clr: wr_data[CB_CLR_B]};
  end
endmodule

// File: rtl/dit_channel.sv
module dit_channel
  import dit_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cmd_wr,
  input  chan_cmd_t    cmd,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  logic ien;
  logic running;
  logic expire;

  assign running = (cnt_o != '0);
  // a command write owns the cycle: no step, no expiry
  assign expire  = !cmd_wr && tick && (cnt_o == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      ien    <= 1'b0;
      flag_o <= 1'b0;
    end else if (cmd_wr) begin
      ien <= cmd.ien;
      if (!cmd.load)    cnt_o <= '0;
      else if (!running) cnt_o <= reload;
      if (cmd.clr)      flag_o <= 1'b0;
    end else if (expire) begin
      cnt_o <= reload;
      if (ien) flag_o <= 1'b1;
    end else if (tick && running) begin
      cnt_o <= cnt_o - W'(1);
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int A_WIDTH = 10,
  parameter int B_WIDTH = 8,
  parameter int A_DIV   = 288,
  parameter int B_DIV   = 2304
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       busy_in,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [A_WIDTH-1:0] reload_a, cnt_a;
  logic [B_WIDTH-1:0] reload_b, cnt_b;
  logic               cmd_wr, tick_a, tick_b, flag_a, flag_b;
  chan_cmd_t          cmd_a, cmd_b;

  dit_regs #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_a(reload_a), .reload_b(reload_b), .cmd_wr(cmd_wr),
    .cmd_a(cmd_a), .cmd_b(cmd_b)
  );

  dit_prescaler #(.DIV(A_DIV)) u_pre_a (.clk(clk), .rst(rst), .tick_o(tick_a));
  dit_prescaler #(.DIV(B_DIV)) u_pre_b (.clk(clk), .rst(rst), .tick_o(tick_b));

  dit_channel #(.W(A_WIDTH)) u_chan_a (
    .clk(clk), .rst(rst), .tick(tick_a), .cmd_wr(cmd_wr), .cmd(cmd_a),
    .reload(reload_a), .cnt_o(cnt_a), .flag_o(flag_a)
  );

  dit_channel #(.W(B_WIDTH)) u_chan_b (
    .clk(clk), .rst(rst), .tick(tick_b), .cmd_wr(cmd_wr), .cmd(cmd_b),
    .reload(reload_b), .cnt_o(cnt_b), .flag_o(flag_b)
  );

  assign status_o = {busy_in, 5'b0, flag_b, flag_a};
  assign irq_o    = flag_a | flag_b;
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int A_WIDTH = 10,
  parameter int B_WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic [7:0]         wr_data,
  input logic [7:0]         status_o,
  input logic               irq_o,
  input logic               tick_a,
  input logic               tick_b,
  input logic [A_WIDTH-1:0] cnt_a,
  input logic [A_WIDTH-1:0] reload_a,
  input logic [B_WIDTH-1:0] cnt_b,
  input logic [B_WIDTH-1:0] reload_b
);
  logic cw;
  assign cw = wr_en && (wr_addr == 8'h27);

  AST_FORCE_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    cw && !wr_data[0] |=> cnt_a == '0); // R4
  AST_FORCE_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    cw && !wr_data[1] |=> cnt_b == '0); // R4
  AST_LOAD_IDLE_A: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[0] && cnt_a == '0 |=> cnt_a == $past(reload_a)); // R5
  AST_LOAD_IDLE_B: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[1] && cnt_b == '0 |=> cnt_b == $past(reload_b)); // R5
  AST_LOAD_BUSY_A: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[0] && cnt_a != '0 |=> cnt_a == $past(cnt_a)); // R5
  AST_LOAD_BUSY_B: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[1] && cnt_b != '0 |=> cnt_b == $past(cnt_b)); // R5
  AST_STEP_A: assert property (@(posedge clk) disable iff (rst)
    !cw && tick_a && cnt_a > A_WIDTH'(1) |=> cnt_a == $past(cnt_a) - A_WIDTH'(1)); // R6
  AST_STEP_B: assert property (@(posedge clk) disable iff (rst)
    !cw && tick_b && cnt_b > B_WIDTH'(1) |=> cnt_b == $past(cnt_b) - B_WIDTH'(1)); // R6
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    !cw && !tick_a |=> $stable(cnt_a)); // R6
  AST_RELOAD_A: assert property (@(posedge clk) disable iff (rst)
    !cw && tick_a && cnt_a == A_WIDTH'(1) |=> cnt_a == $past(reload_a)); // R7
  AST_RELOAD_B: assert property (@(posedge clk) disable iff (rst)
    !cw && tick_b && cnt_b == B_WIDTH'(1) |=> cnt_b == $past(reload_b)); // R7
  AST_CLEAR_A: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[4] |=> !status_o[0]); // R9
  AST_CLEAR_B: assert property (@(posedge clk) disable iff (rst)
    cw && wr_data[5] |=> !status_o[1]); // R9
  AST_STICKY_A: assert property (@(posedge clk) disable iff (rst)
    status_o[0] && !(cw && wr_data[4]) |=> status_o[0]); // R9
  AST_STICKY_B: assert property (@(posedge clk) disable iff (rst)
    status_o[1] && !(cw && wr_data[5]) |=> status_o[1]); // R9
  AST_IRQ_FROM_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status_o[0] | status_o[1])); // R10
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
    status_o[6:2] == 5'b0); // R11
endmodule

bind dual_interval_timer dit_checker #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .status_o(status_o), .irq_o(irq_o), .tick_a(tick_a), .tick_b(tick_b),
  .cnt_a(cnt_a), .reload_a(reload_a), .cnt_b(cnt_b), .reload_b(reload_b)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int ADIV = 2;
  localparam int BDIV = 16;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, busy_in = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [7:0] status_o;
  logic       irq_o;

  int cyc = 0, n_tests = 0, n_fail = 0;
  bit finished = 0;

  dual_interval_timer #(.A_WIDTH(10), .B_WIDTH(8), .A_DIV(ADIV), .B_DIV(BDIV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_in(busy_in), .status_o(status_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called in the negedge region; the write lands on the next posedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(input int bitn, input int limit, output int t, output bit ok);
    ok = 0; t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (status_o[bitn]) begin ok = 1; t = cyc; break; end
    end
  endtask

  task automatic set_a(input int l);
    wr(8'h24, 8'((l >> 2) & 255));
    wr(8'h25, 8'(l & 3));
  endtask

  task automatic measure_a(input int l);
    int tw, t1, t2, d; bit ok;
    wr(8'h27, 8'h30);
    set_a(l);
    wr(8'h27, 8'h05); tw = cyc;
    wait_flag(0, l*ADIV + 4, t1, ok);
    d = t1 - tw;
    chk(ok && d >= (l-1)*ADIV+1 && d <= l*ADIV, "R6", $sformatf("A first expiry L=%0d", l), d, l*ADIV);
    wr(8'h27, 8'h15);
    wait_flag(0, l*ADIV + 4, t2, ok);
    chk(ok && (t2 - t1) == l*ADIV, "R7", $sformatf("A period L=%0d", l), t2 - t1, l*ADIV);
  endtask

  task automatic measure_b(input int l);
    int tw, t1, t2, d; bit ok;
    wr(8'h27, 8'h30);
    wr(8'h26, 8'(l));
    wr(8'h27, 8'h0A); tw = cyc;
    wait_flag(1, l*BDIV + 4, t1, ok);
    d = t1 - tw;
    chk(ok && d >= (l-1)*BDIV+1 && d <= l*BDIV, "R6", $sformatf("B first expiry L=%0d", l), d, l*BDIV);
    chk(irq_o == 1'b1, "R10", "irq with flag B", int'(irq_o), 1);
    wr(8'h27, 8'h2A);
    wait_flag(1, l*BDIV + 4, t2, ok);
    chk(ok && (t2 - t1) == l*BDIV, "R7", $sformatf("B period L=%0d", l), t2 - t1, l*BDIV);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int tw, t1, t2, d; bit ok;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, reload registers zero, counters idle
    chk(status_o == 8'h00, "R1", "status after reset", int'(status_o), 0);
    chk(irq_o == 1'b0, "R1", "irq after reset", int'(irq_o), 0);
    wr(8'h27, 8'h0F);
    idle(4200);
    chk(status_o == 8'h00, "R1", "no expiry from reset contents", int'(status_o), 0);

    // R11: busy passthrough and zero padding
    busy_in = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h80, "R11", "busy bit", int'(status_o), 128);
    busy_in = 1'b0;
    @(negedge clk);
    chk(status_o == 8'h00, "R11", "busy low", int'(status_o), 0);

    // R6/R7: sweep of reload values
    for (int l = 1; l <= 24; l++) measure_a(l);
    measure_a(512);
    measure_a(1023);
    for (int l = 1; l <= 12; l++) measure_b(l);
    measure_b(255);

    // R2: upper bits of 0x25 ignored (0xFD -> low bits 01, L = 1)
    wr(8'h27, 8'h30);
    wr(8'h24, 8'h00); wr(8'h25, 8'hFD);
    wr(8'h27, 8'h05);
    wait_flag(0, 10, t1, ok);
    wr(8'h27, 8'h15);
    wait_flag(0, 10, t2, ok);
    chk(ok && (t2 - t1) == ADIV, "R2", "0x25 high bits ignored", t2 - t1, ADIV);

    // R2: foreign addresses ignored while running L=4
    wr(8'h27, 8'h30);
    set_a(4);
    wr(8'h27, 8'h05);
    wait_flag(0, 20, t1, ok);
    wr(8'h27, 8'h15);
    wr(8'h28, 8'hFF); wr(8'h23, 8'h00); wr(8'h10, 8'h3F);
    wait_flag(0, 20, t2, ok);
    chk(ok && (t2 - t1) == 4*ADIV, "R2", "other addresses ignored", t2 - t1, 4*ADIV);

    // R5 and R7: load while running is ignored; new reload used at next expiry
    wr(8'h27, 8'h30);
    set_a(1000);
    wr(8'h27, 8'h05); tw = cyc;
    idle(20);
    set_a(5);
    wr(8'h27, 8'h05);
    wait_flag(0, 2100, t1, ok);
    d = t1 - tw;
    chk(ok && d >= 999*ADIV+1 && d <= 1000*ADIV, "R5", "load ignored while running", d, 1000*ADIV);
    wr(8'h27, 8'h15);
    wait_flag(0, 20, t2, ok);
    chk(ok && (t2 - t1) == 5*ADIV, "R7", "new reload at next expiry", t2 - t1, 5*ADIV);

    // R4: load bit 0 stops the counter
    wr(8'h27, 8'h30);
    set_a(10);
    wr(8'h27, 8'h05);
    idle(6);
    wr(8'h27, 8'h04);
    idle(100);
    chk(status_o[0] == 1'b0, "R4", "stopped timer does not expire", int'(status_o[0]), 0);
    wr(8'h27, 8'h05); tw = cyc;
    wait_flag(0, 30, t1, ok);
    d = t1 - tw;
    chk(ok && d >= 9*ADIV+1 && d <= 10*ADIV, "R4", "restart after forced zero", d, 10*ADIV);

    // R8: no flag while interrupt disabled
    wr(8'h27, 8'h30);
    set_a(3);
    wr(8'h27, 8'h01);
    idle(50);
    chk(status_o == 8'h00 && irq_o == 1'b0, "R8", "disabled expiry sets nothing", int'(status_o), 0);
    wr(8'h27, 8'h05); tw = cyc;
    wait_flag(0, 10, t1, ok);
    chk(ok && (t1 - tw) <= 3*ADIV, "R8", "flag after enable", t1 - tw, 3*ADIV);

    // R9/R10: flag sticky across disable, cleared by clear bit
    wr(8'h27, 8'h01);
    idle(20);
    chk(status_o[0] == 1'b1, "R9", "flag kept after disable", int'(status_o[0]), 1);
    chk(irq_o == 1'b1, "R10", "irq while flag set", int'(irq_o), 1);
    wr(8'h27, 8'h10);
    chk(status_o == 8'h00, "R9", "flag cleared", int'(status_o), 0);
    chk(irq_o == 1'b0, "R10", "irq low after clear", int'(irq_o), 0);

    // R3: both timers at once, separate clear bits, bits 7..6 inert
    set_a(5);
    wr(8'h26, 8'd2);
    wr(8'h27, 8'hCF);
    wait_flag(1, 40, t1, ok);
    chk(ok && status_o[1:0] == 2'b11, "R3", "both flags set", int'(status_o[1:0]), 3);
    wr(8'h27, 8'h1F);
    chk(status_o[1:0] == 2'b10, "R3", "clear A keeps B", int'(status_o[1:0]), 2);
    wr(8'h27, 8'h2C);
    chk(status_o[1] == 1'b0, "R3", "clear B", int'(status_o[1]), 0);
    wr(8'h27, 8'h30);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule